// File: doc/BRIEF.md
# Packed Halfword Compare Unit

This execution unit sits in the packed-SIMD path of a core's integer pipeline. It receives a 32-bit instruction word and two register operands of width XLEN, split into 16-bit lanes. It recognises five packed compare operations: equality, signed less-than, signed less-or-equal, unsigned less-than and unsigned less-or-equal. Each lane of the result is a full 16-bit mask, all ones where the relation holds between the matching lanes of the two operands and all zeros where it does not.

The result, an illegal-instruction flag and the destination register index are captured into output registers on a rising clock edge when the input strobe is high. Between strobes the outputs hold their values. When the instruction word is not one of the five compares, the unit raises the illegal flag and returns a zero result, so the pipeline can trap. With XLEN of 64 there are four lanes. With XLEN of 32 there are two.

Top module: `simd_cmp16_unit`

## Requirements
- R1: An instruction is accepted only when bits [6:0] equal 7'b1111111, bits [14:12] equal 3'b000, and bits [31:25] hold one of the five operation codes given in R2 to R6.
- R2: Operation code 7'b0100110 writes 16'hFFFF into a lane when the two raw 16-bit lane values are bit-identical, and 16'h0000 otherwise.
- R3: Operation code 7'b0000110 sets a lane mask when the rs1 lane is less than the rs2 lane as two's-complement int16. For example, 16'h8000 against 16'h0001 gives all ones.
- R4: Operation code 7'b0001110 sets a lane mask when the rs1 lane is less than or equal to the rs2 lane as int16.
- R5: Operation code 7'b0010110 sets a lane mask when the rs1 lane is less than the rs2 lane as uint16. For example, 16'h8000 against 16'h0001 gives all zeros.
- R6: Operation code 7'b0011110 sets a lane mask when the rs1 lane is less than or equal to the rs2 lane as uint16.
- R7: Lane i occupies bits [16i+15:16i], with lane 0 in bits [15:0]. Each lane compares only lane i of rs1 with lane i of rs2, and every result lane is either 16'hFFFF or 16'h0000.
- R8: For an instruction rejected by R1, illegal_o is 1 and result_o is zero. For an accepted one, illegal_o is 0.
- R9: Outputs update only on a rising clock edge with valid_i high, and take effect one cycle after the inputs are presented. With valid_i low they hold their previous values.
- R10: rd_o takes the instruction's bits [11:7] whenever valid_i is captured, for both legal and illegal words.
- R11: While rst_ni is low, result_o, illegal_o and rd_o are zero. The reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the current inputs |
| insn_i | input | 32 | Instruction word in R-type layout |
| rs1_i | input | XLEN | First packed operand |
| rs2_i | input | XLEN | Second packed operand |
| result_o | output | XLEN | Per-lane compare masks, registered |
| illegal_o | output | 1 | Instruction is not one of the five compares, registered |
| rd_o | output | 5 | Destination register index, registered |

## Verification
The bench aims at lanes holding 16'h8000, 16'hFFFF, 16'h7FFF and zero, where signed and unsigned ordering disagree. A unit that mixes up signedness, or that flips the sign bit on the wrong operation, returns the inverted mask for those lanes. It uses equal operands to separate the less-than operations from the less-or-equal ones, and an off-by-one there shows up as a missing or extra mask. It sends words with a wrong opcode, a wrong funct3 and an unused funct7, which a loose decoder would accept with a non-zero result. It places operands that give a different outcome in every lane, so that swapped or shared lanes are caught, and it checks that outputs hold while the strobe is low.

// File: rtl/simd_cmp16_pkg.sv
package simd_cmp16_pkg;

  localparam int unsigned LANE_W = 16;

  localparam logic [6:0] OPC_PACKED = 7'b1111111;
  localparam logic [2:0] F3_CMP     = 3'b000;

  localparam logic [6:0] F7_EQ  = 7'b0100110;
  localparam logic [6:0] F7_SLT = 7'b0000110;
  localparam logic [6:0] F7_SLE = 7'b0001110;
  localparam logic [6:0] F7_ULT = 7'b0010110;
  localparam logic [6:0] F7_ULE = 7'b0011110;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_LE = 2'd2
  } cmp_kind_e;

  typedef struct packed {
    cmp_kind_e kind;
    logic      is_signed;
    logic      illegal;
  } cmp_ctrl_t;

endpackage

// File: rtl/simd_cmp16_dec.sv
module simd_cmp16_dec
  import simd_cmp16_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  output cmp_ctrl_t  ctrl_o
);

  logic known_f7;

  always_comb begin
    ctrl_o.kind      = CMP_EQ;
    ctrl_o.is_signed = 1'b0;
    known_f7         = 1'b1;
    unique case (funct7_i)
      F7_EQ:  ctrl_o.kind = CMP_EQ;
      F7_SLT: begin ctrl_o.kind = CMP_LT; ctrl_o.is_signed = 1'b1; end
      F7_SLE: begin ctrl_o.kind = CMP_LE; ctrl_o.is_signed = 1'b1; end
      F7_ULT: ctrl_o.kind = CMP_LT;
      F7_ULE: ctrl_o.kind = CMP_LE;
      default: known_f7 = 1'b0;
    endcase
    ctrl_o.illegal = (opcode_i != OPC_PACKED) || (funct3_i != F3_CMP) || !known_f7;
  end

endmodule

// File: rtl/simd_cmp16_lane.sv
module simd_cmp16_lane
  import simd_cmp16_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  cmp_kind_e         kind_i,
  input  logic              signed_i,
  output logic [LANE_W-1:0] mask_o
);

  // Signed order equals unsigned order once the sign bits are inverted.
  logic [LANE_W-1:0] a_x, b_x;
  logic              eq, lt, hit;

  assign a_x = {a_i[LANE_W-1] ^ signed_i, a_i[LANE_W-2:0]};
  assign b_x = {b_i[LANE_W-1] ^ signed_i, b_i[LANE_W-2:0]};
  assign eq  = (a_i == b_i);
  assign lt  = (a_x < b_x);

  always_comb begin
    unique case (kind_i)
      CMP_EQ:  hit = eq;
      CMP_LT:  hit = lt;
      CMP_LE:  hit = lt | eq;
      default: hit = 1'b0;
    endcase
  end

  assign mask_o = {LANE_W{hit}};

endmodule

// File: rtl/simd_cmp16_unit.sv
module simd_cmp16_unit
  import simd_cmp16_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o,
  output logic [4:0]      rd_o
);

  localparam int unsigned LANES = XLEN / LANE_W;

  cmp_ctrl_t       ctrl;
  logic [XLEN-1:0] mask;
  logic            unused_rs_fields;

  assign unused_rs_fields = ^insn_i[24:15];

  simd_cmp16_dec u_dec (
    .opcode_i (insn_i[6:0]),
    .funct3_i (insn_i[14:12]),
    .funct7_i (insn_i[31:25]),
    .ctrl_o   (ctrl)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_cmp16_lane u_lane (
      .a_i      (rs1_i[i*LANE_W +: LANE_W]),
      .b_i      (rs2_i[i*LANE_W +: LANE_W]),
      .kind_i   (ctrl.kind),
      .signed_i (ctrl.is_signed),
      .mask_o   (mask[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
    end else if (valid_i) begin
      result_o  <= ctrl.illegal ? '0 : mask;
      illegal_o <= ctrl.illegal;
      rd_o      <= insn_i[11:7];
    end
  end

endmodule

// File: rtl/simd_cmp16_unit_chk.sv
module simd_cmp16_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic [4:0]      rd_o
);

  localparam int unsigned LANES = XLEN / 16;

  logic past_ok;
  logic unused_chk;
  assign unused_chk = ^insn_i[24:15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R8
  p_illegal_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));

  // R1
  p_bad_opcode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) && ($past(insn_i[6:0]) != 7'b1111111) |-> illegal_o);

  // R9
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(valid_i) |-> $stable(result_o) && $stable(illegal_o) && $stable(rd_o));

  // R10
  p_rd_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) |-> rd_o == $past(insn_i[11:7]));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R7
    p_lane_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (result_o[i*16 +: 16] == 16'h0000) || (result_o[i*16 +: 16] == 16'hFFFF));

    // R2
    p_eq_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(valid_i) && ($past(insn_i[6:0]) == 7'b1111111) &&
      ($past(insn_i[14:12]) == 3'b000) && ($past(insn_i[31:25]) == 7'b0100110)
      |-> result_o[i*16 +: 16] ==
          (($past(rs1_i[i*16 +: 16]) == $past(rs2_i[i*16 +: 16])) ? 16'hFFFF : 16'h0000));
  end

endmodule

bind simd_cmp16_unit simd_cmp16_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .rs1_i     (rs1_i),
  .rs2_i     (rs2_i),
  .result_o  (result_o),
  .illegal_o (illegal_o),
  .rd_o      (rd_o)
);

// File: tb/simd_cmp16_unit_test.sv
module simd_cmp16_unit_test;

  localparam int unsigned XLEN       = 64;
  localparam int unsigned LANES      = XLEN / 16;
  localparam time         CLK_PERIOD = 10ns;

  localparam logic [6:0] F_EQ  = 7'b0100110;
  localparam logic [6:0] F_SLT = 7'b0000110;
  localparam logic [6:0] F_SLE = 7'b0001110;
  localparam logic [6:0] F_ULT = 7'b0010110;
  localparam logic [6:0] F_ULE = 7'b0011110;
  localparam logic [6:0] OPC   = 7'b1111111;

  typedef struct {
    logic [XLEN-1:0] result;
    logic            illegal;
    logic [4:0]      rd;
    string           req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [XLEN-1:0] rs1_i = '0;
  logic [XLEN-1:0] rs2_i = '0;
  logic [XLEN-1:0] result_o;
  logic            illegal_o;
  logic [4:0]      rd_o;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];
  exp_t last_exp;
  logic pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cmp16_unit #(.XLEN(XLEN)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .insn_i    (insn_i),
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .result_o  (result_o),
    .illegal_o (illegal_o),
    .rd_o      (rd_o)
  );

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [6:0] f7, logic [2:0] f3, logic [6:0] op, logic [4:0] rd);
    return {f7, 5'd7, 5'd3, f3, rd, op};
  endfunction

  function automatic exp_t model(logic [31:0] insn, logic [XLEN-1:0] a, logic [XLEN-1:0] b, string req);
    exp_t e;
    logic legal;
    logic [6:0] f7;
    f7 = insn[31:25];
    legal = (insn[6:0] == OPC) && (insn[14:12] == 3'b000) &&
            (f7 == F_EQ || f7 == F_SLT || f7 == F_SLE || f7 == F_ULT || f7 == F_ULE);
    e.result  = '0;
    e.illegal = !legal;
    e.rd      = insn[11:7];
    e.req     = req;
    if (legal) begin
      for (int i = 0; i < LANES; i++) begin
        logic [15:0] x, y;
        logic h;
        x = a[i*16 +: 16];
        y = b[i*16 +: 16];
        case (f7)
          F_EQ:    h = (x == y);
          F_SLT:   h = ($signed(x) <  $signed(y));
          F_SLE:   h = ($signed(x) <= $signed(y));
          F_ULT:   h = (x <  y);
          default: h = (x <= y);
        endcase
        e.result[i*16 +: 16] = h ? 16'hFFFF : 16'h0000;
      end
    end
    return e;
  endfunction

  task automatic drive(logic [31:0] insn, logic [XLEN-1:0] a, logic [XLEN-1:0] b, string req);
    @(negedge clk);
    insn_i  = insn;
    rs1_i   = a;
    rs2_i   = b;
    valid_i = 1'b1;
    sb_q.push_back(model(insn, a, b, req));
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid_i = 1'b0;
    insn_i  = mk(F_EQ, 3'b000, OPC, 5'd31);
    rs1_i   = {XLEN{1'b1}};
    rs2_i   = {XLEN{1'b1}};
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(posedge clk) pend <= valid_i && rst_ni;

  always @(negedge clk) begin
    if (pend) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected capture: actual %h expected none", result_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "result", result_o, e.result);
        check(e.illegal ? "R8" : "R1", "illegal", XLEN'(illegal_o), XLEN'(e.illegal));
        check("R10", "rd", XLEN'(rd_o), XLEN'(e.rd));
        last_exp = e;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset result", result_o, '0);
    check("R11", "reset illegal", XLEN'(illegal_o), '0);
    check("R11", "reset rd", XLEN'(rd_o), '0);
    rst_ni = 1'b1;

    // R2 equality incl. raw-bit match of sign-bit patterns
    drive(mk(F_EQ, 3'b000, OPC, 5'd1), 64'h1234_8000_FFFF_0000, 64'h1234_8001_FFFF_0001, "R2");
    // R3 / R5 signedness divergence on 0x8000 vs 0x0001
    drive(mk(F_SLT, 3'b000, OPC, 5'd2), 64'h8000_8000_FFFF_7FFF, 64'h0001_0001_0000_8000, "R3");
    drive(mk(F_ULT, 3'b000, OPC, 5'd3), 64'h8000_8000_FFFF_7FFF, 64'h0001_0001_0000_8000, "R5");
    // R4 / R6 equal operands separate LE from LT
    drive(mk(F_SLE, 3'b000, OPC, 5'd4), 64'h8000_0005_FFFF_7FFF, 64'h8000_0004_0000_7FFF, "R4");
    drive(mk(F_ULE, 3'b000, OPC, 5'd5), 64'h8000_0005_FFFF_7FFF, 64'h8000_0004_0000_7FFF, "R6");
    drive(mk(F_SLT, 3'b000, OPC, 5'd6), 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, "R3");
    drive(mk(F_ULT, 3'b000, OPC, 5'd7), 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, "R5");
    // R7 every lane a different outcome
    drive(mk(F_ULT, 3'b000, OPC, 5'd8), 64'h0001_0005_0003_0000, 64'h0002_0004_0004_0000, "R7");
    drive(mk(F_SLE, 3'b000, OPC, 5'd9), 64'hFFFF_0001_8000_7FFF, 64'h0000_0000_8001_8000, "R7");
    // R8 illegal: wrong opcode, wrong funct3, unused funct7
    drive(mk(F_EQ, 3'b000, 7'b0110011, 5'd10), 64'h5, 64'h5, "R8");
    drive(mk(F_EQ, 3'b001, OPC, 5'd11), 64'h5, 64'h5, "R8");
    drive(mk(7'b0101110, 3'b000, OPC, 5'd12), 64'h5, 64'h5, "R8");
    drive(mk(7'b0100111, 3'b000, OPC, 5'd13), 64'h0, 64'h0, "R8");

    // Random mix
    for (int k = 0; k < 60; k++) begin
      logic [6:0] f7;
      logic [XLEN-1:0] a, b;
      case ($urandom_range(0, 5))
        0: f7 = F_EQ;  1: f7 = F_SLT; 2: f7 = F_SLE;
        3: f7 = F_ULT; 4: f7 = F_ULE; default: f7 = 7'($urandom);
      endcase
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 3 == 0) b[15:0] = a[15:0];
      if (k % 4 == 1) b[47:32] = a[47:32] ^ 16'h8000;
      drive(mk(f7, 3'b000, OPC, 5'($urandom)), a, b, "R7");
    end

    // R9 hold while strobe low
    idle(4);
    check("R9", "hold result", result_o, last_exp.result);
    check("R9", "hold illegal", XLEN'(illegal_o), XLEN'(last_exp.illegal));
    check("R9", "hold rd", XLEN'(rd_o), XLEN'(last_exp.rd));

    // R11 asynchronous reset mid-run
    drive(mk(F_EQ, 3'b000, OPC, 5'd17), 64'h0, 64'h0, "R2");
    idle(1);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R11", "async reset result", result_o, '0);
    check("R11", "async reset rd", XLEN'(rd_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(mk(F_ULE, 3'b000, OPC, 5'd18), 64'hFFFF_0000_0000_0001, 64'h0000_FFFF_0000_0000, "R6");
    idle(2);

    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 pending items: actual %0d expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule